// File: doc/BRIEF.md
# Lockable display configuration register file

This block is the register bank of a display controller. It sits behind a simple synchronous register bus. One configuration register drives the controller's shutdown and blink-rate controls. Three setup registers hold an intensity value, the grid count and a shift limit. A small output-map table is reached indirectly, through a pointer register and a data window.

The configuration register has a lock bit. While the lock is set, writes to the grid register, the shift-limit register and the map data window are dropped. This protects those settings from stray writes by failing software. Everything stays readable. The pointer also stays writable, so the map contents can still be walked and read back while they are locked. The configuration register can always be written, so software can clear the lock again.

Reads are combinational from the address. A read strobe tells the block that a read took place, which matters only for the map window because that access advances the pointer.

Top module: `lkcfg_regfile`

## Requirements
- R1: After reset every register, the pointer and every map entry are zero. `shutdown_o` is 1, `blink_sel_o` is 0 and every mapped address reads 0x00.
- R2: A write to the configuration register at 0x04 is stored and reads back unchanged. Its bit 0 is the run bit, and `shutdown_o` is its inverse. Its bit 2 appears on `blink_sel_o`.
- R3: While configuration bit 1 (the lock) is 1, writes to the grid register at 0x03, the shift-limit register at 0x0E and the map window at 0x06 leave their contents unchanged.
- R4: Locked registers read back their stored values while the lock is set.
- R5: The intensity register at 0x02 accepts writes whatever the lock state.
- R6: The pointer at 0x05 accepts writes whatever the lock state. It keeps the low log2(MAP_DEPTH) bits of the write data and reads back zero-extended.
- R7: Address 0x06 reads the map entry selected by the pointer and, when unlocked, writes that entry. Each write or read strobe at 0x06 advances the pointer by one, even while locked. The pointer wraps from MAP_DEPTH-1 to 0.
- R8: The configuration register is writable while locked, so writing bit 1 as 0 removes the lock.
- R9: A read of an unmapped address returns 0x00. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| shutdown_o | output | 1 | 1 when the controller is shut down |
| blink_sel_o | output | 1 | Blink rate select |

## Verification
Most internal state is visible at the ports within one cycle. A stored value that is wrong shows on `rdata_o` as soon as its address is presented, and a wrong run or blink bit shows on the two control outputs on the cycle after the write. The pointer is the exception. A pointer that steps wrongly stays hidden until the next access to the map window or to the pointer address, and from then on it shows up as a misordered data stream. For this reason the map sequence and the pointer value are checked after every locked and unlocked window access.

// File: rtl/lkcfg_pkg.sv
package lkcfg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_INTEN = 8'h02;
  localparam logic [ADDR_W-1:0] A_GRIDS = 8'h03;
  localparam logic [ADDR_W-1:0] A_CFG   = 8'h04;
  localparam logic [ADDR_W-1:0] A_PTR   = 8'h05;
  localparam logic [ADDR_W-1:0] A_MAP   = 8'h06;
  localparam logic [ADDR_W-1:0] A_SHIFT = 8'h0E;

  localparam int N_SETUP = 3;
  localparam logic [N_SETUP*ADDR_W-1:0] SETUP_ADDR = {A_SHIFT, A_GRIDS, A_INTEN};
  localparam logic [N_SETUP-1:0]        SETUP_LOCKABLE = 3'b110;

  typedef struct packed {
    logic [4:0] aux;
    logic       blink_sel;
    logic       lock;
    logic       run;
  } cfg_t;

  function automatic logic is_mapped(logic [ADDR_W-1:0] a);
    return a == A_INTEN || a == A_GRIDS || a == A_CFG ||
           a == A_PTR   || a == A_MAP   || a == A_SHIFT;
  endfunction
endpackage

// File: rtl/lkcfg_setup_reg.sv
module lkcfg_setup_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         lock_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_o <= '0;
    else if (wr_i && !lock_i) q_o <= d_i;
  end
endmodule

// File: rtl/lkcfg_map.sv
module lkcfg_map #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_we_i,
  input  logic [PW-1:0] ptr_d_i,
  input  logic          step_i,
  input  logic          mem_we_i,
  input  logic [W-1:0]  mem_d_i,
  output logic [PW-1:0] ptr_o,
  output logic [W-1:0]  mem_q_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (mem_we_i) mem_q[ptr_o] <= mem_d_i;
      if (ptr_we_i)    ptr_o <= ptr_d_i;
      else if (step_i) ptr_o <= ptr_o + 1'b1;  // power-of-two depth: natural wrap
    end
  end

  assign mem_q_o = mem_q[ptr_o];
endmodule

// File: rtl/lkcfg_regfile.sv
module lkcfg_regfile
  import lkcfg_pkg::*;
#(
  parameter int MAP_DEPTH = 16,
  localparam int PTR_W    = $clog2(MAP_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              shutdown_o,
  output logic              blink_sel_o
);
  logic [DATA_W-1:0] cfg_raw;
  cfg_t              cfg_q;
  logic [DATA_W-1:0] setup_q [N_SETUP];
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] map_q;
  logic hit_cfg, hit_ptr, hit_map;

  assign hit_cfg = addr_i == A_CFG;
  assign hit_ptr = addr_i == A_PTR;
  assign hit_map = addr_i == A_MAP;

  lkcfg_setup_reg #(.W(DATA_W)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i   (we_i && hit_cfg),
    .lock_i (1'b0),
    .d_i    (wdata_i),
    .q_o    (cfg_raw)
  );
  assign cfg_q = cfg_t'(cfg_raw);

  for (genvar g = 0; g < N_SETUP; g++) begin : g_setup
    lkcfg_setup_reg #(.W(DATA_W)) u_reg (
      .clk_i, .rst_ni,
      .wr_i   (we_i && addr_i == SETUP_ADDR[g*ADDR_W +: ADDR_W]),
      .lock_i (SETUP_LOCKABLE[g] && cfg_q.lock),
      .d_i    (wdata_i),
      .q_o    (setup_q[g])
    );
  end

  lkcfg_map #(.DEPTH(MAP_DEPTH), .W(DATA_W)) u_map (
    .clk_i, .rst_ni,
    .ptr_we_i (we_i && hit_ptr),
    .ptr_d_i  (wdata_i[PTR_W-1:0]),
    .step_i   ((we_i || rd_i) && hit_map),
    .mem_we_i (we_i && hit_map && !cfg_q.lock),
    .mem_d_i  (wdata_i),
    .ptr_o    (ptr_q),
    .mem_q_o  (map_q)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_cfg) rdata_o = cfg_raw;
    if (hit_ptr) rdata_o = DATA_W'(ptr_q);
    if (hit_map) rdata_o = map_q;
    for (int i = 0; i < N_SETUP; i++)
      if (addr_i == SETUP_ADDR[i*ADDR_W +: ADDR_W]) rdata_o = setup_q[i];
  end

  assign shutdown_o  = ~cfg_q.run;
  assign blink_sel_o = cfg_q.blink_sel;
endmodule

// File: rtl/lkcfg_regfile_chk.sv
module lkcfg_regfile_chk
  import lkcfg_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              shutdown_o,
  input logic              blink_sel_o,
  input logic [DATA_W-1:0] cfg_raw,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [DATA_W-1:0] grids_q,
  input logic [DATA_W-1:0] shift_q,
  input logic [DATA_W-1:0] inten_q
);
  always_comb
    if (!rst_ni) a_r1_reset_shutdown: assert (shutdown_o && !blink_sel_o);

  a_r2_ctrl_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_CFG |=> shutdown_o == !$past(wdata_i[0]) && blink_sel_o == $past(wdata_i[2]));

  a_r3_grids_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_raw[1] && we_i && addr_i == A_GRIDS |=> $stable(grids_q));

  a_r3_shift_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_raw[1] && we_i && addr_i == A_SHIFT |=> $stable(shift_q));

  a_r5_inten_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_INTEN |=> inten_q == $past(wdata_i));

  a_r6_ptr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_PTR |=> ptr_q == $past(wdata_i[PTR_W-1:0]));

  a_r7_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i || rd_i) && addr_i == A_MAP |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));

  a_r8_cfg_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_CFG |=> cfg_raw == $past(wdata_i));

  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_mapped(addr_i) |-> rdata_o == '0);
endmodule

bind lkcfg_regfile lkcfg_regfile_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rd_i, .rdata_o,
  .shutdown_o, .blink_sel_o,
  .cfg_raw (cfg_raw),
  .ptr_q   (ptr_q),
  .inten_q (setup_q[0]),
  .grids_q (setup_q[1]),
  .shift_q (setup_q[2])
);

// File: tb/lkcfg_regfile_bench.sv
`timescale 1ns/1ps
module lkcfg_regfile_bench;
  import lkcfg_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic we_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic shutdown_o, blink_sel_o;

  always #2.5 clk_i = ~clk_i;

  lkcfg_regfile u_lkcfg_regfile (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] m_cfg = '0, m_inten = '0, m_grids = '0, m_shift = '0;
  logic [3:0] m_ptr = '0;
  logic [7:0] m_map [16];
  initial for (int i = 0; i < 16; i++) m_map[i] = '0;

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      A_CFG:   return m_cfg;
      A_INTEN: return m_inten;
      A_GRIDS: return m_grids;
      A_SHIFT: return m_shift;
      A_PTR:   return {4'h0, m_ptr};
      A_MAP:   return m_map[m_ptr];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(string tag);
    chk({tag, " shutdown"}, {7'h0, shutdown_o}, {7'h0, ~m_cfg[0]});
    chk({tag, " blink"}, {7'h0, blink_sel_o}, {7'h0, m_cfg[2]});
  endtask

  task automatic do_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    case (a)
      A_CFG:   m_cfg = d;
      A_INTEN: m_inten = d;
      A_GRIDS: if (!m_cfg[1]) m_grids = d;
      A_SHIFT: if (!m_cfg[1]) m_shift = d;
      A_PTR:   m_ptr = d[3:0];
      A_MAP:   begin if (!m_cfg[1]) m_map[m_ptr] = d; m_ptr = m_ptr + 1'b1; end
      default: ;
    endcase
    @(posedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic do_rd(logic [7:0] a, string tag);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 chk(tag, rdata_o, exp_rd(a));
    if (a == A_MAP) m_ptr = m_ptr + 1'b1;
    @(posedge clk_i); #1;
    rd_i = 1'b0;
  endtask

  task automatic rd_all(string tag);
    do_rd(A_CFG, tag); do_rd(A_INTEN, tag); do_rd(A_GRIDS, tag);
    do_rd(A_SHIFT, tag); do_rd(A_PTR, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  logic [7:0] addr_pool [8] = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0E, 8'h07, 8'hFF};

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk_outs("R1 in reset");
    rst_ni = 1'b1;
    chk_outs("R1 after reset");
    rd_all("R1 reset read");
    do_rd(A_MAP, "R1 map reset");

    do_wr(A_CFG, 8'h05);  @(negedge clk_i); chk_outs("R2 run+blink");
    do_rd(A_CFG, "R2 cfg readback");
    do_wr(A_GRIDS, 8'h3A); do_wr(A_SHIFT, 8'h11); do_wr(A_INTEN, 8'h07);
    do_wr(A_PTR, 8'h00);
    do_wr(A_MAP, 8'hA1); do_wr(A_MAP, 8'hB2); do_wr(A_MAP, 8'hC3);
    do_rd(A_PTR, "R7 ptr after 3 writes");
    do_wr(A_PTR, 8'hF0); do_rd(A_PTR, "R6 ptr masked");

    do_wr(A_CFG, 8'h07); // lock
    do_wr(A_GRIDS, 8'hFF); do_wr(A_SHIFT, 8'hEE);
    do_rd(A_GRIDS, "R3 R4 grids locked"); do_rd(A_SHIFT, "R3 R4 shift locked");
    do_wr(A_INTEN, 8'h55); do_rd(A_INTEN, "R5 inten while locked");
    do_wr(A_PTR, 8'h01); do_rd(A_PTR, "R6 ptr write while locked");
    do_wr(A_MAP, 8'h99);
    do_rd(A_PTR, "R7 ptr step on locked write");
    do_wr(A_PTR, 8'h00);
    do_rd(A_MAP, "R3 R4 map0"); do_rd(A_MAP, "R3 map1 locked"); do_rd(A_MAP, "R4 map2");

    do_wr(A_CFG, 8'h01); // unlock
    do_rd(A_CFG, "R8 unlock readback");
    do_wr(A_GRIDS, 8'h0C); do_rd(A_GRIDS, "R8 grids after unlock");

    do_wr(A_PTR, 8'h0F); do_wr(A_MAP, 8'h5F);
    do_rd(A_PTR, "R7 wrap after write");
    do_wr(A_PTR, 8'h0F); do_rd(A_MAP, "R7 read last entry");
    do_rd(A_PTR, "R7 wrap after read");

    do_rd(8'h07, "R9 unmapped read"); do_rd(8'h80, "R9 unmapped read hi");
    do_wr(8'h07, 8'hFF); do_wr(8'h00, 8'hFF);
    rd_all("R9 after unmapped write");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = ($urandom % 4 == 0) ? 8'($urandom) : addr_pool[$urandom % 8];
      if ($urandom % 2 == 0) begin
        do_wr(a, 8'($urandom));
        @(negedge clk_i); chk_outs("R2 random");
      end else begin
        do_rd(a, "R3 R4 R7 R9 random read");
      end
    end
    rd_all("R4 final");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule